// File: doc/BRIEF.md
# Serial Token Packet Receiver

This block turns a sampled serial line into a decoded token packet. Each bit-rate strobe gives one line sample. The samples are NRZI-decoded, and the stuffed bits that follow long runs of ones are removed. The block then collects four fields in order: an 8-bit packet identifier, a 7-bit device address, a 4-bit endpoint and a 5-bit check code. An upstream sync detector marks the packet with a start pulse and an end pulse.

When the end pulse arrives, the block reports the result one clock later. A well-formed packet gives a single-cycle valid pulse with the packet type, address and endpoint, together with two flags: one for an identifier whose check nibble is wrong, and one for a failed CRC5. A packet of the wrong length gives a length-error pulse in place of the valid pulse.

Top module: `tok_rx`

## Requirements
- R1: NRZI decode. A strobed level equal to the previous level decodes as 1, and a changed level decodes as 0. The reference level for the first bit is the line level sampled in the cycle where `sop_i` is high.
- R2: Decoded bits are taken least significant bit first: PID in bits 0..7, address in bits 8..14, endpoint in bits 15..18, CRC field in bits 19..23. On a valid packet, `pid_type_o` is PID[3:0], `addr_o` is the address and `endp_o` is the endpoint. Endpoint 0 is reported like any other endpoint.
- R3: After six consecutive decoded 1 bits, the next strobed bit is discarded whatever its level, and the ones run starts again from zero.
- R4: `pid_err_o` is high with the valid pulse exactly when PID[7:4] is not the bitwise complement of PID[3:0].
- R5: A CRC5 with polynomial x^5+x^2+1 is preset to 11111 and shifts serially over the 16 bits from address bit 0 to CRC bit 4. `crc_err_o` is high with the valid pulse exactly when the final register is not 01100. A sender places the inverted register bit 4-i in CRC field bit i.
- R6: The outputs respond in the cycle after `eop_i` is sampled. `pkt_vld_o` is a one-cycle pulse, issued only when exactly 24 bits were kept after unstuffing. `pid_err_o` and `crc_err_o` are asserted only together with `pkt_vld_o`.
- R7: If the number of kept bits is not 24, `len_err_o` pulses for one cycle and `pkt_vld_o` stays low.
- R8: Strobes and `eop_i` seen outside a packet produce no output. Outside a packet means before any `sop_i`, or after an `eop_i` and before the next `sop_i`.
- R9: A `sop_i` in the middle of a packet discards the partial packet and starts a new one.
- R10: After reset, all output pulses and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One line sample per bit period |
| line_i | input | 1 | Received line level |
| sop_i | input | 1 | Start of packet; samples the NRZI reference level |
| eop_i | input | 1 | End of packet |
| pkt_vld_o | output | 1 | One-cycle pulse for a packet of correct length |
| pid_type_o | output | 4 | Packet type (low PID nibble) |
| addr_o | output | 7 | Device address |
| endp_o | output | 4 | Endpoint number |
| pid_err_o | output | 1 | PID check nibble mismatch |
| crc_err_o | output | 1 | CRC5 residual mismatch |
| len_err_o | output | 1 | Wrong packet length |

## Verification
The bench sends packets with sparse ones (small address, endpoint 0), which gives many level toggles and no stuffing. It also sends all-ones address and endpoint, which forces stuffed bits, once with a stuffed bit at the toggling level and once at the unchanged level; this shows that the discard depends on the run count and not on the bit value. A bad check nibble and a single flipped CRC bit are each sent alone, so each flag is seen on its own. Short and long packets, stray strobes outside a packet, and a restart in mid-packet show that length errors, ignored input and restart are all handled correctly.

// File: rtl/tok_rx_pkg.sv
package tok_rx_pkg;
  localparam int unsigned CRC_W = 5;
  localparam logic [CRC_W-1:0] CRC_POLY  = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_INIT  = 5'b11111;
  localparam logic [CRC_W-1:0] CRC_RESID = 5'b01100;
endpackage

// File: rtl/tok_rx_nrzi.sv
module tok_rx_nrzi #(
  parameter int unsigned STUFF_RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic sop_i,
  input  logic active_i,
  input  logic line_i,
  output logic bit_vld_o,
  output logic bit_o
);
  localparam int unsigned RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);

  logic             prev_q;
  logic [RUN_W-1:0] ones_q;
  logic             take, stuff;

  assign take      = stb_i & active_i & ~sop_i;
  assign stuff     = (ones_q == RUN_MAX);
  assign bit_o     = (line_i == prev_q);
  assign bit_vld_o = take & ~stuff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      ones_q <= '0;
    end else if (sop_i) begin
      prev_q <= line_i;
      ones_q <= '0;
    end else if (take) begin
      prev_q <= line_i;
      if (stuff)      ones_q <= '0;
      else if (bit_o) ones_q <= ones_q + 1'b1;
      else            ones_q <= '0;
    end
  end

  // R3
  ones_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= RUN_MAX);
  // R3
  stuff_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && ones_q == RUN_MAX) |=> (ones_q == '0));
endmodule

// File: rtl/tok_rx_crc5.sv
module tok_rx_crc5
  import tok_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             d_i,
  output logic [CRC_W-1:0] res_o
);
  logic fb;
  assign fb = res_o[CRC_W-1] ^ d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_o <= CRC_INIT;
    else if (clr_i) res_o <= CRC_INIT;
    else if (en_i)  res_o <= {res_o[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  // R5
  crc_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (res_o == CRC_INIT));
endmodule

// File: rtl/tok_rx.sv
module tok_rx
  import tok_rx_pkg::*;
#(
  parameter int unsigned PID_W     = 8,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned ENDP_W    = 4,
  parameter int unsigned STUFF_RUN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              line_i,
  input  logic              sop_i,
  input  logic              eop_i,
  output logic              pkt_vld_o,
  output logic [PID_W/2-1:0] pid_type_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ENDP_W-1:0] endp_o,
  output logic              pid_err_o,
  output logic              crc_err_o,
  output logic              len_err_o
);
  localparam int unsigned TYP_W    = PID_W / 2;
  localparam int unsigned HDR_BITS = PID_W + ADDR_W + ENDP_W;
  localparam int unsigned PKT_BITS = HDR_BITS + CRC_W;
  localparam int unsigned CNT_W    = $clog2(PKT_BITS + 2);
  localparam logic [CNT_W-1:0] PID_END = CNT_W'(PID_W);
  localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] PKT_LEN = CNT_W'(PKT_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(PKT_BITS + 1);

  logic                active_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic                dbit_vld, dbit;
  logic                crc_en;
  logic [CRC_W-1:0]    crc_res;
  logic                eop_act;

  tok_rx_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (bit_stb_i),
    .sop_i    (sop_i),
    .active_i (active_q),
    .line_i   (line_i),
    .bit_vld_o(dbit_vld),
    .bit_o    (dbit)
  );

  assign crc_en = dbit_vld && (cnt_q >= PID_END) && (cnt_q < PKT_LEN);

  tok_rx_crc5 u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sop_i),
    .en_i  (crc_en),
    .d_i   (dbit),
    .res_o (crc_res)
  );

  assign eop_act = eop_i & active_q & ~sop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      hdr_q    <= '0;
    end else if (sop_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (eop_act) begin
      active_q <= 1'b0;
    end else if (dbit_vld) begin
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < HDR_END)  hdr_q <= {dbit, hdr_q[HDR_BITS-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_vld_o  <= 1'b0;
      len_err_o  <= 1'b0;
      pid_err_o  <= 1'b0;
      crc_err_o  <= 1'b0;
      pid_type_o <= '0;
      addr_o     <= '0;
      endp_o     <= '0;
    end else begin
      pkt_vld_o <= 1'b0;
      len_err_o <= 1'b0;
      pid_err_o <= 1'b0;
      crc_err_o <= 1'b0;
      if (eop_act) begin
        if (cnt_q == PKT_LEN) begin
          pkt_vld_o  <= 1'b1;
          pid_type_o <= hdr_q[TYP_W-1:0];
          addr_o     <= hdr_q[PID_W +: ADDR_W];
          endp_o     <= hdr_q[PID_W+ADDR_W +: ENDP_W];
          pid_err_o  <= (hdr_q[TYP_W +: TYP_W] != ~hdr_q[TYP_W-1:0]);
          crc_err_o  <= (crc_res != CRC_RESID);
        end else begin
          len_err_o <= 1'b1;
        end
      end
    end
  end

  // R6
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |=> !pkt_vld_o);
  // R6
  vld_after_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_vld_o || len_err_o) |-> $past(eop_i));
  // R7
  vld_len_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_vld_o && len_err_o));
  // R6
  flag_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pid_err_o || crc_err_o) |-> pkt_vld_o);
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !sop_i) |=> (!pkt_vld_o && !len_err_o));
endmodule

// File: tb/sim_tok_rx.sv
module sim_tok_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, line = 1'b1, sop = 1'b0, eop = 1'b0;
  logic       pkt_vld, pid_err, crc_err, len_err;
  logic [3:0] pid_type, endp;
  logic [6:0] addr;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    bit         len_bad;
    logic [3:0] typ;
    logic [6:0] ad;
    logic [3:0] ep;
    bit         pid_bad;
    bit         crc_bad;
  } exp_t;
  exp_t q[$];

  always #5ns clk = ~clk;

  tok_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(stb), .line_i(line),
    .sop_i(sop), .eop_i(eop), .pkt_vld_o(pkt_vld), .pid_type_o(pid_type),
    .addr_o(addr), .endp_o(endp), .pid_err_o(pid_err), .crc_err_o(crc_err),
    .len_err_o(len_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (pkt_vld || len_err)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected output", {pkt_vld, len_err}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(len_err == e.len_bad, "R7 len_err", len_err, e.len_bad);
        chk(pkt_vld == !e.len_bad, "R6 pkt_vld", pkt_vld, !e.len_bad);
        if (!e.len_bad) begin
          chk(pid_type == e.typ, "R2 pid_type", pid_type, e.typ);
          chk(addr == e.ad, "R2 addr", addr, e.ad);
          chk(endp == e.ep, "R2 endp", endp, e.ep);
          chk(pid_err == e.pid_bad, "R4 pid_err", pid_err, e.pid_bad);
          chk(crc_err == e.crc_bad, "R5 crc_err", crc_err, e.crc_bad);
        end
      end
    end
  end

  logic lvl;

  task automatic strobe_bit(input logic b);
    if (!b) lvl = ~lvl;
    @(negedge clk); stb = 1'b1; line = lvl;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic start_pkt();
    lvl = 1'b1;
    @(negedge clk); sop = 1'b1; line = lvl;
    @(negedge clk); sop = 1'b0;
  endtask

  task automatic end_pkt();
    @(negedge clk); eop = 1'b1;
    @(negedge clk); eop = 1'b0;
    @(negedge clk);
    chk(!pkt_vld && !len_err, "R6 single-cycle pulse", {pkt_vld, len_err}, 0);
  endtask

  function automatic logic [4:0] crc_field(input logic [10:0] d);
    logic [4:0] c = 5'b11111;
    logic [4:0] f;
    for (int i = 0; i < 11; i++) begin
      logic fb = c[4] ^ d[i];
      c = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end
    for (int i = 0; i < 5; i++) f[i] = ~c[4-i];
    return f;
  endfunction

  task automatic send(input logic [3:0] typ, input logic [3:0] hi,
                      input logic [6:0] ad, input logic [3:0] ep,
                      input bit crc_flip, input int nbits, input logic stuff_val);
    logic [31:0] data;
    logic [4:0]  cf;
    int          ones = 0;
    exp_t        e;
    cf = crc_field({ep, ad});
    if (crc_flip) cf[2] = ~cf[2];
    data = {8'h00, cf, ep, ad, hi, typ};
    e.len_bad = (nbits != 24);
    e.typ = typ; e.ad = ad; e.ep = ep;
    e.pid_bad = (hi != ~typ);
    e.crc_bad = crc_flip;
    q.push_back(e);
    start_pkt();
    for (int i = 0; i < nbits; i++) begin
      strobe_bit(data[i]);
      ones = data[i] ? ones + 1 : 0;
      if (ones == 6) begin
        strobe_bit(stuff_val);
        ones = 0;
      end
    end
    end_pkt();
  endtask

  initial begin
    #2ms;
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk({pkt_vld, pid_err, crc_err, len_err} == 4'b0, "R10 reset outputs",
        {pkt_vld, pid_err, crc_err, len_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R5 R6: plain packets
    send(4'b1001, 4'b0110, 7'h05, 4'h1, 1'b0, 24, 1'b0);
    send(4'b0101, 4'b1010, 7'h00, 4'h0, 1'b0, 24, 1'b0);
    send(4'b1101, 4'b0010, 7'h2a, 4'h9, 1'b0, 24, 1'b0);
    // R3: long ones runs, stuffed bit toggling then not toggling
    send(4'b0001, 4'b1110, 7'h7f, 4'hf, 1'b0, 24, 1'b0);
    send(4'b0001, 4'b1110, 7'h7f, 4'hf, 1'b0, 24, 1'b1);
    // R4: bad check nibble
    send(4'b1001, 4'b1001, 7'h11, 4'h3, 1'b0, 24, 1'b0);
    // R5: corrupted CRC
    send(4'b1001, 4'b0110, 7'h11, 4'h3, 1'b1, 24, 1'b0);
    // R7: short and long
    send(4'b1001, 4'b0110, 7'h12, 4'h2, 1'b0, 20, 1'b0);
    send(4'b1001, 4'b0110, 7'h12, 4'h2, 1'b0, 25, 1'b0);
    // R8: strobes and eop outside a packet
    for (int i = 0; i < 30; i++) strobe_bit(i[0]);
    @(negedge clk); eop = 1'b1;
    @(negedge clk); eop = 1'b0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0 && !pkt_vld && !len_err, "R8 no output outside packet",
        q.size(), 0);
    send(4'b1110, 4'b0001, 7'h33, 4'h7, 1'b0, 24, 1'b0);
    // R9: restart mid-packet
    start_pkt();
    for (int i = 0; i < 9; i++) strobe_bit(1'b0);
    send(4'b0011, 4'b1100, 7'h4c, 4'h5, 1'b0, 24, 1'b0);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 all expected packets reported", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule